// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control half of a dual-slope integrating converter. After a start request it first shorts the integrator for an auto-zero interval. It then connects the unknown input for a fixed number of clocks. Last, it connects the opposite-polarity reference and counts clocks until the comparator reports that the integrator has come back to zero. The count is kept in binary-coded decimal, so the held result can drive a four-digit display directly. The display has its decimal point after the leading digit, so a count of 5000 reads 5.000.

The comparator bit arrives from the analog side with no timing relationship to the clock. It passes through a two-flop synchronizer. The synchronizer delay is compensated inside the sequencer, so the result equals the number of high comparator samples and has no pipeline offset. A count that would pass 9999 ends the conversion early with a saturated result and an overrange flag. A one-cycle done pulse marks each completion. The result, the overrange flag and the decimal-point enable then hold until the next conversion finishes.

Top module: `dsc_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, all three switch selects, done_pulse, overrange and dp_en are 0, and result_bcd is 0000.
- R2: A start_req sampled high while the block is idle clears the counter and raises sel_zero for exactly ZERO_CYCLES (default 100) cycles, beginning on the next cycle.
- R3: Directly after auto-zero, sel_input is high for exactly INTEG_CYCLES (default 1000) cycles. sel_ref follows on the next cycle.
- R4: At most one of sel_zero, sel_input and sel_ref is high in any cycle, and they always occur in the order zero, input, reference, then idle.
- R5: The comparator is sampled at the clock edge that ends each cycle. The result equals the number of consecutive high samples, counted from the sample that ends the last input cycle. done_pulse rises at the second edge after the edge that first samples the comparator low.
- R6: result_bcd holds four BCD digits, with the most significant digit in bits [15:12] and the least significant in [3:0]. A count of 5000 reads 16'h5000.
- R7: If a 10000th high sample arrives, the conversion ends at that edge with result 9999 and overrange set. Exactly 9999 high samples give 9999 with overrange clear.
- R8: dp_en is 1 while the held result is in range. It is 0 after reset and while overrange is held.
- R9: done_pulse is high for exactly one cycle per completion. result_bcd, overrange and dp_en change only at a completion and otherwise hold.
- R10: A start_req during any of the auto-zero, input or reference phases is ignored, and the conversion timing is unchanged.
- R11: A comparator that is already low when the input phase ends gives a result of 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Conversion request, acted on only when idle |
| cmp_above | input | 1 | Asynchronous comparator bit, high while the integrator is past zero |
| sel_zero | output | 1 | Short the integrator (auto-zero) |
| sel_input | output | 1 | Connect the unknown input to the integrator |
| sel_ref | output | 1 | Connect the reference to the integrator |
| result_bcd | output | 16 | Held conversion result, four BCD digits |
| dp_en | output | 1 | Light the decimal point after the leading digit |
| done_pulse | output | 1 | One-cycle completion strobe |
| overrange | output | 1 | Held result saturated at 9999 |

## Verification
The assertions check the following on every cycle: the switch selects are mutually exclusive and follow their order, the auto-zero and input phase lengths are exact, the result digits are valid BCD, done is a single cycle, the held outputs are stable between completions, and an overrange result is all nines. Only the bench scenarios can show the end-to-end count. They drive a behavioural integrator through the selects and check that the count equals the ceiling of input × INTEG_CYCLES / reference. They also check the latency of the synchronizer compensation, the 9999/10000 boundary, the zero-input case, and requests that arrive mid-conversion and must be ignored.

// File: rtl/dsc_pkg.sv
// Shared types for the dual-slope conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dsc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ZERO  = 2'd1,
        PH_INTEG = 2'd2,
        PH_DEINT = 2'd3
    } phase_e;

    localparam int BCD_W = 4;
endpackage

// File: rtl/dsc_sync.sv
// Multi-stage synchronizer for one asynchronous bit.
// Assumes: STAGES >= 1; output lags the input by STAGES edges.
module dsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    // Shift the sampled bit through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                sh_q[i] <= sh_q[i-1];
            end
        end
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/dsc_bcd_digit.sv
// One decade of a BCD counter: counts 0..9, wraps to 0 when enabled at 9.
// Assumes: clr has priority over en.
module dsc_bcd_digit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    output logic [3:0] digit,
    output logic       at_nine
);
    // Decade state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit <= 4'd0;
        end else if (clr) begin
            digit <= 4'd0;
        end else if (en) begin
            digit <= at_nine ? 4'd0 : digit + 4'd1;
        end
    end

    assign at_nine = (digit == 4'd9);
endmodule

// File: rtl/dsc_bcd_counter.sv
// Chain of BCD decades with ripple carry enables.
// Assumes: caller stops incrementing when full is high (saturation is external).
module dsc_bcd_counter
    import dsc_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     inc,
    output logic [BCD_W*DIGITS-1:0]  value,
    output logic                     full
);
    logic [DIGITS-1:0] carry;
    logic [DIGITS-1:0] nine;

    assign carry[0] = inc;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        dsc_bcd_digit u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .en      (carry[g]),
            .digit   (value[BCD_W*g +: BCD_W]),
            .at_nine (nine[g])
        );
        if (g < DIGITS - 1) begin : g_carry
            assign carry[g+1] = carry[g] & nine[g];
        end
    end

    assign full = &nine;
endmodule

// File: rtl/dsc_sequencer.sv
// Dual-slope conversion sequencer: auto-zero, fixed input integration,
// reference de-integration with a gated BCD count, held result.
// Assumes: cmp_above is asynchronous and high while the integrator is past
// zero; SYNC_STAGES >= 2 so the hold-off compensation is non-empty.
module dsc_sequencer
    import dsc_pkg::*;
#(
    parameter int ZERO_CYCLES  = 100,
    parameter int INTEG_CYCLES = 1000,
    parameter int DIGITS       = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_req,
    input  logic                    cmp_above,
    output logic                    sel_zero,
    output logic                    sel_input,
    output logic                    sel_ref,
    output logic [BCD_W*DIGITS-1:0] result_bcd,
    output logic                    dp_en,
    output logic                    done_pulse,
    output logic                    overrange
);
    localparam int RES_W   = BCD_W * DIGITS;
    localparam int TMR_MAX = (ZERO_CYCLES > INTEG_CYCLES) ? ZERO_CYCLES : INTEG_CYCLES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] ZERO_LAST  = TMR_W'(ZERO_CYCLES - 1);
    localparam logic [TMR_W-1:0] INTEG_LAST = TMR_W'(INTEG_CYCLES - 1);
    localparam logic [TMR_W-1:0] HOLD_N     = TMR_W'(SYNC_STAGES - 1);
    localparam logic [TMR_W-1:0] TMR_ONE    = TMR_W'(1);

    phase_e            phase_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              cmp_sync;
    logic [RES_W-1:0]  cnt_val;
    logic              cnt_full;
    logic              in_hold;
    logic              finish;
    logic              cnt_inc;
    logic              cnt_clr;
    logic [RES_W-1:0]  result_q;
    logic              ovr_q;
    logic              dp_q;
    logic              done_q;

    dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_above),
        .q     (cmp_sync)
    );

    dsc_bcd_counter #(.DIGITS(DIGITS)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .value (cnt_val),
        .full  (cnt_full)
    );

    // Reference-phase control: skip the synchronizer latency, then gate the count.
    always_comb begin
        in_hold = (phase_q == PH_DEINT) && (tmr_q < HOLD_N);
        finish  = (phase_q == PH_DEINT) && !in_hold && (!cmp_sync || cnt_full);
        cnt_inc = (phase_q == PH_DEINT) && !in_hold && cmp_sync && !cnt_full;
        cnt_clr = (phase_q == PH_IDLE) && start_req;
    end

    // Phase sequencing and the shared phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            tmr_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_req) begin
                        phase_q <= PH_ZERO;
                        tmr_q   <= '0;
                    end
                end
                PH_ZERO: begin
                    if (tmr_q == ZERO_LAST) begin
                        phase_q <= PH_INTEG;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + TMR_ONE;
                    end
                end
                PH_INTEG: begin
                    if (tmr_q == INTEG_LAST) begin
                        phase_q <= PH_DEINT;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + TMR_ONE;
                    end
                end
                default: begin
                    if (in_hold) begin
                        tmr_q <= tmr_q + TMR_ONE;
                    end else if (finish) begin
                        phase_q <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    // Capture the count and status at completion; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            ovr_q    <= 1'b0;
            dp_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                result_q <= cnt_val;
                ovr_q    <= cmp_sync;
                dp_q     <= !cmp_sync;
            end
        end
    end

    assign sel_zero   = (phase_q == PH_ZERO);
    assign sel_input  = (phase_q == PH_INTEG);
    assign sel_ref    = (phase_q == PH_DEINT);
    assign result_bcd = result_q;
    assign overrange  = ovr_q;
    assign dp_en      = dp_q;
    assign done_pulse = done_q;
endmodule

// File: rtl/dsc_sequencer_chk.sv
// Property checker for dsc_sequencer, attached by bind.
// Assumes: synchronous active-low reset held for at least one edge.
module dsc_sequencer_chk #(
    parameter int ZERO_CYCLES  = 100,
    parameter int INTEG_CYCLES = 1000,
    parameter int DIGITS       = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_req,
    input logic                  sel_zero,
    input logic                  sel_input,
    input logic                  sel_ref,
    input logic [4*DIGITS-1:0]   result_bcd,
    input logic                  dp_en,
    input logic                  done_pulse,
    input logic                  overrange
);
    logic [31:0] zrun_q;
    logic [31:0] irun_q;

    // Run-length counters for the auto-zero and input phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun_q <= '0;
            irun_q <= '0;
        end else begin
            zrun_q <= sel_zero  ? zrun_q + 32'd1 : 32'd0;
            irun_q <= sel_input ? irun_q + 32'd1 : 32'd0;
        end
    end

    function automatic logic digits_ok(logic [4*DIGITS-1:0] x);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (x[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    assert_zero_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_zero) |-> zrun_q == 32'(ZERO_CYCLES));

    assert_integ_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_input) |-> (irun_q == 32'(INTEG_CYCLES)) && sel_ref);

    assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_zero, sel_input, sel_ref}));

    assert_input_after_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_input) |-> $past(sel_zero));

    assert_ref_after_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref) |-> $past(sel_input));

    assert_zero_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_zero) |-> $past(start_req && !sel_input && !sel_ref));

    assert_valid_digits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        digits_ok(result_bcd));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrange |-> result_bcd == {DIGITS{4'h9}});

    assert_dp_off_overrange_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dp_en |-> !overrange);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_done_after_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(sel_ref) && !sel_ref);

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !done_pulse) |-> $stable(result_bcd) && $stable(overrange) && $stable(dp_en));
endmodule

bind dsc_sequencer dsc_sequencer_chk #(
    .ZERO_CYCLES  (ZERO_CYCLES),
    .INTEG_CYCLES (INTEG_CYCLES),
    .DIGITS       (DIGITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .sel_zero   (sel_zero),
    .sel_input  (sel_input),
    .sel_ref    (sel_ref),
    .result_bcd (result_bcd),
    .dp_en      (dp_en),
    .done_pulse (done_pulse),
    .overrange  (overrange)
);

// File: tb/dsc_sequencer_tb.sv
// Bench: behavioural integrator and phase model, compared every cycle.
module dsc_sequencer_tb;
    localparam int ZC = 100;
    localparam int IC = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        cmp_above;
    logic        sel_zero, sel_input, sel_ref, dp_en, done_pulse, overrange;
    logic [15:0] result_bcd;

    always #4 clk = ~clk;

    // Behavioural integrator: input adds va per cycle, reference removes rr.
    int va = 0;
    int rr = 1;
    int v  = 0;
    assign cmp_above = (v > 0);

    dsc_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cmp_above(cmp_above),
        .sel_zero(sel_zero), .sel_input(sel_input), .sel_ref(sel_ref),
        .result_bcd(result_bcd), .dp_en(dp_en), .done_pulse(done_pulse),
        .overrange(overrange)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Reference model state: 0 idle, 1 zero, 2 input, 3 reference.
    int m_ph = 0, m_left = 0, m_t = 0;
    bit m_done = 0, m_ovr = 0, m_dp = 0;
    int m_hold = 0;

    function automatic logic [15:0] to_bcd(int x);
        logic [15:0] r;
        int d = 1;
        for (int i = 0; i < 4; i++) begin
            r[4*i +: 4] = 4'((x / d) % 10);
            d = d * 10;
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // Model advance at each edge, plus watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_done = 0; m_ovr = 0; m_dp = 0; m_hold = 0;
        end else begin
            m_done = 0;
            case (m_ph)
                0: if (start_req) begin m_ph = 1; m_left = ZC; end
                1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = IC; end end
                2: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_ph = 3;
                        m_t = (IC * va + rr - 1) / rr;
                        m_left = (m_t >= 10000) ? 10001 : m_t + 2;
                    end
                end
                default: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_ph = 0; m_done = 1;
                        m_ovr = (m_t > 9999);
                        m_dp = !m_ovr;
                        m_hold = m_ovr ? 9999 : m_t;
                    end
                end
            endcase
        end
    end

    // Mid-cycle compare, then integrator update for this cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sel_zero  == (m_ph == 1), "R2 sel_zero",  int'(sel_zero),  int'(m_ph == 1));
            chk(sel_input == (m_ph == 2), "R3 sel_input", int'(sel_input), int'(m_ph == 2));
            chk(sel_ref   == (m_ph == 3), "R4 sel_ref",   int'(sel_ref),   int'(m_ph == 3));
            chk(done_pulse == m_done, "R5 done timing", int'(done_pulse), int'(m_done));
            chk(result_bcd == to_bcd(m_hold), "R9 held result", int'(result_bcd), int'(to_bcd(m_hold)));
            chk(overrange == m_ovr, "R7 overrange", int'(overrange), int'(m_ovr));
            chk(dp_en == m_dp, "R8 dp_en", int'(dp_en), int'(m_dp));
        end
        case (m_ph)
            1: v = 0;
            2: v = v + va;
            3: v = v - rr;
            default: ;
        endcase
    end

    task automatic convert(int a, int r, int exp, bit exp_ovr, bit poke, string req);
        va = a; rr = r;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            start_req = 1'b1;  // R10 during auto-zero
            @(negedge clk) start_req = 1'b0;
            chk(result_bcd == to_bcd(m_hold), "R9 result held mid-run", int'(result_bcd), int'(to_bcd(m_hold)));
            repeat (1100) @(negedge clk);
            start_req = 1'b1;  // R10 during reference phase
            @(negedge clk) start_req = 1'b0;
        end
        while (done_pulse !== 1'b1) @(negedge clk);
        chk(result_bcd == to_bcd(exp), req, int'(result_bcd), int'(to_bcd(exp)));
        chk(overrange == exp_ovr, "R7 overrange flag", int'(overrange), int'(exp_ovr));
        chk(dp_en == !exp_ovr, "R8 decimal point", int'(dp_en), int'(!exp_ovr));
        @(negedge clk);
        chk(done_pulse == 1'b0, "R9 done one cycle", int'(done_pulse), 0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({sel_zero, sel_input, sel_ref, done_pulse, overrange, dp_en} == 6'b0,
            "R1 controls in reset", int'({sel_zero, sel_input, sel_ref, done_pulse, overrange, dp_en}), 0);
        chk(result_bcd == 16'h0000, "R1 result in reset", int'(result_bcd), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(result_bcd == 16'h0000 && !dp_en, "R1 after release", int'(result_bcd), 0);

        convert(5, 1, 5000, 1'b0, 1'b0, "R6 5V reads 5000");
        chk(result_bcd == 16'h5000, "R6 digit layout", int'(result_bcd), 16'h5000);
        convert(3, 7, 429, 1'b0, 1'b0, "R5 ceil count 429");
        convert(0, 1, 0, 1'b0, 1'b0, "R11 zero input");
        convert(9999, 1000, 9999, 1'b0, 1'b0, "R7 exactly 9999");
        convert(10, 1, 9999, 1'b1, 1'b0, "R7 saturate at 9999");
        convert(1, 4, 250, 1'b0, 1'b1, "R10 ignored starts");
        chk(sel_zero == 1'b0, "R10 no restart", int'(sel_zero), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule